// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers interrupt requests for a small processor core and decides which one is presented next. Two external pins, two timer overflow pulses and a serial port request feed it. Software configures it through a small register write port. Each source has its own enable bit. A master enable gates all of them, and no source bypasses it. A priority register lifts chosen sources into a high level. Each external pin can be set to sense either a falling edge or a low level.

The controller shows one registered request and a 3-bit source index to the core. The core accepts the request by pulsing an acknowledge. The controller then marks that priority level as in service and drops the request. While a low-level routine runs, only a high-level source can interrupt it. While a high-level routine runs, nothing can. A return strobe from the core ends the innermost active routine and reopens its level. Vector lookup, stacking and instruction decode are left to the core.

Top module: `irq_ctrl`

## Requirements
- R1: After reset there is no request, and every source enable, the master enable, every priority bit, every trigger mode and both in-service flags are clear.
- R2: The enable register (address 0) holds one enable per source in bits 4:0. Bit order is ext0=0, timer0=1, ext1=2, timer1=3, serial=4, and the same numbers are the grant index. A disabled source is never requested. A latched request of a disabled source stays pending until the source is enabled.
- R3: Bit 5 of the enable register is the master enable. While it is clear, no request reaches the core.
- R4: Among eligible sources of the same level, the lowest index is granted first.
- R5: Priority register (address 2'd1) bit n = 1 puts source n in the high level. An eligible high-level source is granted ahead of any low-level source, whatever the indices.
- R6: While a low-level routine is in service, only high-level sources can be requested. While a high-level routine is in service, no source is requested.
- R7: A return strobe clears the high in-service flag if it is set, and otherwise the low one.
- R8: With mode register (address 2'd2) bit i = 1, external pin i is falling-edge sensed. After a two-flop synchronizer, a high-to-low transition sets a latch. An acknowledge of that source clears the latch. A pin held low after that does not request again.
- R9: With mode bit i = 0, external pin i is level sensed. It requests whenever its synchronized value is low and is not latched.
- R10: A one-cycle timer overflow pulse sets a latched request that persists until that source is acknowledged.
- R11: The request output is registered. A timer pulse sampled on clock edge k raises the request after edge k+1. An acknowledge sampled while the request is high drops the request on that edge and marks the granted level in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select: 0 enable, 1 priority, 2 trigger mode |
| cfg_wdata_i | input | 6 | Register write data |
| ext_pin_i | input | 2 | Raw external interrupt pins, idle high |
| tmr_ovf_i | input | 2 | Timer overflow pulses, one cycle each |
| ser_req_i | input | 1 | Serial port request, level |
| irq_ack_i | input | 1 | Core accepts the presented request |
| reti_i | input | 1 | Core finished the current service routine |
| irq_req_o | output | 1 | Request toward the core |
| irq_idx_o | output | 3 | Index of the requested source |

## Verification
A timer pulse driven before clock edge k shows as a request after edge k+1. A level-sensed pin change shows two edges after it is first sampled, and a falling edge three edges after. An acknowledge drops the request on the edge that samples it. The bench drives inputs and samples outputs on falling clock edges. It checks the timer latency on the exact cycles on both sides. Every check that a request is absent waits six cycles, which is beyond the slowest of these paths. Grants are compared in arrival order against a queue of expected indices, so a wrong order or an extra request is reported whatever its timing.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_EXT  = 2;
    localparam int NUM_SRC  = 2 * NUM_EXT + 1;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int CFG_W    = NUM_SRC + 1;
    localparam int ADDR_W   = 2;
    localparam int GEN_BIT  = NUM_SRC;

    localparam logic [ADDR_W-1:0] REG_EN   = 2'd0;
    localparam logic [ADDR_W-1:0] REG_PRIO = 2'd1;
    localparam logic [ADDR_W-1:0] REG_MODE = 2'd2;

    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic req_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic flag;
    } det_st_t;

    det_st_t st_d, st_q;
    logic    fall_w;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        fall_w  = st_q.s3 && !st_q.s2;
        if (edge_mode_i) begin
            st_d.flag = (st_q.flag && !clr_i) || fall_w;
        end else begin
            st_d.flag = 1'b0;
        end
        req_o = edge_mode_i ? st_q.flag : !st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assert_edge_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && clr_i && !fall_w) |=> !st_q.flag);

    assert_level_unlatched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode_i |=> !st_q.flag);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  src_vec_t         elig_i,
    input  src_vec_t         prio_i,
    input  logic             ins_hi_i,
    input  logic             ins_lo_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             lvl_o
);
    src_vec_t hi_w, lo_w;

    function automatic logic [IDX_W-1:0] first_set(src_vec_t v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    always_comb begin
        hi_w    = elig_i & prio_i;
        lo_w    = elig_i & ~prio_i;
        valid_o = 1'b0;
        idx_o   = '0;
        lvl_o   = 1'b0;
        if (!ins_hi_i) begin
            if (|hi_w) begin
                valid_o = 1'b1;
                lvl_o   = 1'b1;
                idx_o   = first_set(hi_w);
            end else if (!ins_lo_i && |lo_w) begin
                valid_o = 1'b1;
                idx_o   = first_set(lo_w);
            end
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic [NUM_EXT-1:0] ext_pin_i,
    input  logic [NUM_EXT-1:0] tmr_ovf_i,
    input  logic              ser_req_i,
    input  logic              irq_ack_i,
    input  logic              reti_i,
    output logic              irq_req_o,
    output logic [IDX_W-1:0]  irq_idx_o
);
    typedef struct packed {
        src_vec_t           en;
        logic               gen;
        src_vec_t           prio;
        logic [NUM_EXT-1:0] mode;
        logic [NUM_EXT-1:0] tflag;
        logic               ins_hi;
        logic               ins_lo;
        logic               req;
        logic               lvl;
        logic [IDX_W-1:0]   idx;
    } ctrl_st_t;

    ctrl_st_t           state_d, state_q;
    logic               ack_fire;
    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_EXT-1:0] ext_clr;
    src_vec_t           pend;
    src_vec_t           elig;
    logic               arb_valid;
    logic [IDX_W-1:0]   arb_idx;
    logic               arb_lvl;

    assign ack_fire = irq_ack_i && state_q.req;

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        assign ext_clr[g] = ack_fire && (state_q.idx == IDX_W'(2 * g));
        irq_pin_detect u_det (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_i       (ext_pin_i[g]),
            .edge_mode_i (state_q.mode[g]),
            .clr_i       (ext_clr[g]),
            .req_o       (ext_req[g])
        );
    end

    always_comb begin
        pend = '0;
        for (int i = 0; i < NUM_EXT; i++) begin
            pend[2 * i]     = ext_req[i];
            pend[2 * i + 1] = state_q.tflag[i];
        end
        pend[NUM_SRC-1] = ser_req_i;
        elig = pend & state_q.en & {NUM_SRC{state_q.gen}};
    end

    irq_arbiter u_arb (
        .elig_i   (elig),
        .prio_i   (state_q.prio),
        .ins_hi_i (state_q.ins_hi),
        .ins_lo_i (state_q.ins_lo),
        .valid_o  (arb_valid),
        .idx_o    (arb_idx),
        .lvl_o    (arb_lvl)
    );

    always_comb begin
        state_d = state_q;
        if (cfg_we_i) begin
            case (cfg_addr_i)
                REG_EN: begin
                    state_d.en  = cfg_wdata_i[NUM_SRC-1:0];
                    state_d.gen = cfg_wdata_i[GEN_BIT];
                end
                REG_PRIO: state_d.prio = cfg_wdata_i[NUM_SRC-1:0];
                REG_MODE: state_d.mode = cfg_wdata_i[NUM_EXT-1:0];
                default: ;
            endcase
        end
        for (int i = 0; i < NUM_EXT; i++) begin
            if (ack_fire && state_q.idx == IDX_W'(2 * i + 1)) state_d.tflag[i] = 1'b0;
            if (tmr_ovf_i[i]) state_d.tflag[i] = 1'b1;
        end
        if (reti_i) begin
            if (state_q.ins_hi) state_d.ins_hi = 1'b0;
            else                state_d.ins_lo = 1'b0;
        end
        if (ack_fire) begin
            if (state_q.lvl) state_d.ins_hi = 1'b1;
            else             state_d.ins_lo = 1'b1;
        end
        state_d.req = arb_valid && !ack_fire;
        state_d.idx = arb_idx;
        state_d.lvl = arb_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_req_o = state_q.req;
    assign irq_idx_o = state_q.idx;

    assert_global_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.gen |=> !state_q.req);

    assert_hi_blocks_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ins_hi |=> !state_q.req);

    assert_lo_only_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ins_lo |=> (!state_q.req || state_q.lvl));

    assert_ack_drops_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> !state_q.req);

    assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.req |-> (state_q.idx < IDX_W'(NUM_SRC)));

    assert_reti_inner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && state_q.ins_hi && !ack_fire) |=> (!state_q.ins_hi && $stable(state_q.ins_lo)));
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
    import irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [NUM_EXT-1:0] ext_pin = '1;
    logic [NUM_EXT-1:0] tmr_ovf = '0;
    logic              ser_req = 1'b0;
    logic              ack = 1'b0;
    logic              reti = 1'b0;
    logic              irq_req;
    logic [IDX_W-1:0]  irq_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    irq_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .ext_pin_i   (ext_pin),
        .tmr_ovf_i   (tmr_ovf),
        .ser_req_i   (ser_req),
        .irq_ack_i   (ack),
        .reti_i      (reti),
        .irq_req_o   (irq_req),
        .irq_idx_o   (irq_idx)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every presented request and acknowledges it.
    always @(negedge clk) begin
        if (ack) begin
            ack = 1'b0;
        end else if (rst_n && irq_req) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected request", int'(irq_idx), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(irq_idx == IDX_W'(e), "R4 R5 grant index", int'(irq_idx), e);
            end
            ack = 1'b1;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [CFG_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_tmr(logic [NUM_EXT-1:0] m);
        @(negedge clk); tmr_ovf = m;
        @(negedge clk); tmr_ovf = '0;
    endtask

    task automatic reti_pulse();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    task automatic push(int i);
        exp_q.push_back(i);
    endtask

    task automatic wait_size(int n, string tag);
        for (int t = 0; t < 200 && exp_q.size() > n; t++) @(negedge clk);
        chk(exp_q.size() <= n, tag, exp_q.size(), n);
    endtask

    task automatic chk_idle(string tag);
        tick(6);
        chk(irq_req == 1'b0, tag, int'(irq_req), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state, nothing enabled
        chk(irq_req == 1'b0, "R1 no request after reset", int'(irq_req), 0);
        pulse_tmr(2'b01);
        chk_idle("R1 enables clear after reset");

        // R3: master enable off masks an enabled source
        wr(REG_EN, 6'h02);
        pulse_tmr(2'b01);
        chk_idle("R3 master enable masks");
        push(1);
        wr(REG_EN, 6'h22);
        wait_size(0, "R3 R10 pending timer granted after master enable");
        reti_pulse();

        // R2 R10: disabled source held pending
        wr(REG_EN, 6'h3D);
        pulse_tmr(2'b01);
        chk_idle("R2 disabled source not requested");
        push(1);
        wr(REG_EN, 6'h3F);
        wait_size(0, "R2 R10 latched request kept until enabled");
        reti_pulse();

        // R4 R6 R7: fixed order inside the low level, low blocks low
        push(1); push(3); push(4);
        pulse_tmr(2'b11);
        ser_req = 1'b1;
        wait_size(2, "R4 first grant");
        chk_idle("R6 low in service blocks low");
        reti_pulse();
        wait_size(1, "R7 reti reopens low level");
        reti_pulse();
        wait_size(0, "R4 serial last");
        ser_req = 1'b0;
        reti_pulse();
        chk_idle("R7 all serviced");

        // R5: high level beats default order
        wr(REG_PRIO, 6'h08);
        push(3); push(1);
        pulse_tmr(2'b11);
        wait_size(1, "R5 high source first");
        chk_idle("R6 high in service blocks low");
        reti_pulse();
        wait_size(0, "R5 low source after reti");
        reti_pulse();

        // R6 R7: preemption and in-service unwinding
        push(1);
        pulse_tmr(2'b01);
        wait_size(0, "R6 low service entered");
        push(3);
        pulse_tmr(2'b10);
        wait_size(0, "R6 high preempts low");
        pulse_tmr(2'b01);
        chk_idle("R6 high service blocks all");
        reti_pulse();
        chk_idle("R7 reti cleared high only");
        push(1);
        reti_pulse();
        wait_size(0, "R7 second reti reopens low");
        reti_pulse();
        wr(REG_PRIO, 6'h00);

        // R8: falling edge mode on ext0
        wr(REG_MODE, 6'h01);
        push(0);
        @(negedge clk); ext_pin[0] = 1'b0;
        wait_size(0, "R8 falling edge requested");
        reti_pulse();
        chk_idle("R8 held low does not re-request");
        ext_pin[0] = 1'b1;
        tick(4);

        // R9: level mode on ext1
        push(2);
        @(negedge clk); ext_pin[1] = 1'b0;
        wait_size(0, "R9 low level requested");
        push(2);
        reti_pulse();
        wait_size(0, "R9 level re-requests while low");
        ext_pin[1] = 1'b1;
        tick(4);
        reti_pulse();
        chk_idle("R9 released pin no request");

        // R11: exact timer latency
        push(3);
        @(negedge clk); tmr_ovf = 2'b10;
        @(negedge clk); tmr_ovf = 2'b00;
        chk(irq_req == 1'b0, "R11 request not yet after sampling edge", int'(irq_req), 0);
        @(negedge clk);
        chk(irq_req == 1'b1, "R11 request one edge later", int'(irq_req), 1);
        wait_size(0, "R11 grant popped");
        tick(1);
        chk(irq_req == 1'b0, "R11 ack drops request", int'(irq_req), 0);
        reti_pulse();
        chk_idle("R11 idle at end");
        chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule